// File: doc/BRIEF.md
# DRAM Clock-Enable Power State Tracker

This block follows the low-power state of a DRAM device as seen from the controller side. It watches an active-low clock-enable pin, sampled once per clock edge, together with an already decoded command and a one-bit summary that says whether any bank holds an open row. It keeps the enable level from the previous edge. On each edge it picks the action from four things: the previous level, the current level, the state before the edge and the command. The states it tracks are normal operation, precharge power-down, active power-down and self refresh.

Each edge result appears one cycle later on registered outputs. These are the current state, one-cycle entry and exit pulses, and an error flag for illegal combinations. After the device leaves self refresh, a window of `XS_CYC` edges opens. During that window any command other than deselect or no-operation raises a window violation. If the DLL was off when the device left self refresh, a read within the next `DLL_CYC` edges raises a DLL violation. A controller or protocol monitor uses these flags to catch power-sequencing mistakes.

Top module: `cke_power_tracker`

## Requirements
- R1: After synchronous reset the state is normal (code 0), every flag output is low, and the stored previous enable level is low.
- R2: State codes are normal 0, precharge power-down 1, active power-down 2, self refresh 3. In a low-power state, an enable that is high on both the previous and current edge keeps the state, and the command is ignored: no flag rises.
- R3: In a low-power state, an enable that was high on the previous edge and is low now returns the state to normal and pulses `exit_o`. If the command on that edge is anything other than deselect or no-operation, `err_o` is also raised.
- R4: In normal state, an enable that was low and is now high, with deselect or no-operation, enters precharge power-down when `bank_active` is low and active power-down when it is high, and pulses `enter_o`.
- R5: In normal state, a low-to-high enable with auto-refresh and `bank_active` low enters self refresh and pulses `enter_o`. The same edge with `bank_active` high is illegal: `err_o` rises and the state stays normal.
- R6: An enable that is low on both edges in normal state keeps normal operation, and every command passes without an error.
- R7: Leaving self refresh opens a window covering the next `XS_CYC` edges. On any of those edges in normal state, a command other than deselect or no-operation raises `xs_viol_o`. After the window closes, no window violation is raised.
- R8: If `dll_off` is high on the self-refresh exit edge, a read with low enable on both edges within the next `DLL_CYC` edges raises `dll_viol_o`. Later reads, and reads after an exit with `dll_off` low, raise nothing.
- R9: Any other combination raises `err_o` and leaves the state unchanged. This covers a low-to-high enable in normal state with a command that is neither deselect, no-operation nor a legal auto-refresh, and any high previous enable level while in normal state.
- R10: Command codes are deselect 0, no-operation 1, activate 2, read 3, write 4, precharge 5, auto-refresh 6, mode-register set 7. All outputs change only on the edge after the inputs they report.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cke_n | input | 1 | Active-low clock-enable level at this edge |
| cmd | input | 3 | Decoded command registered at this edge |
| bank_active | input | 1 | High when any bank has an open row |
| dll_off | input | 1 | High when the DLL is disabled at the self-refresh exit edge |
| pstate_o | output | 2 | Current power state |
| enter_o | output | 1 | Pulse: a low-power state was entered |
| exit_o | output | 1 | Pulse: a low-power state was left |
| err_o | output | 1 | Illegal enable/state/command combination |
| xs_viol_o | output | 1 | Non-idle command inside the self-refresh exit window |
| dll_viol_o | output | 1 | Read before the DLL lock interval elapsed |

## Verification
The assertions assume that `cke_n`, `cmd`, `bank_active` and `dll_off` are stable around the rising edge and are never unknown after reset. They also assume that `XS_CYC` and `DLL_CYC` are at least one. The bench changes every input only at the falling clock edge and uses only the eight defined command codes. It drives the illegal sequences deliberately, so `err_o` is exercised without breaking those input assumptions.

// File: rtl/cke_tracker_pkg.sv
package cke_tracker_pkg;

  typedef enum logic [1:0] {
    PS_NORM = 2'd0,
    PS_PPD  = 2'd1,
    PS_APD  = 2'd2,
    PS_SREF = 2'd3
  } pstate_e;

  typedef enum logic [2:0] {
    C_DESEL = 3'd0,
    C_NOP   = 3'd1,
    C_ACT   = 3'd2,
    C_READ  = 3'd3,
    C_WRITE = 3'd4,
    C_PRE   = 3'd5,
    C_REF   = 3'd6,
    C_MRS   = 3'd7
  } cmd_e;

  function automatic logic is_quiet(input cmd_e c);
    return (c == C_DESEL) || (c == C_NOP);
  endfunction

endpackage

// File: rtl/cke_hold_timer.sv
module cke_hold_timer #(
  parameter int LEN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic busy
);
  localparam int W = $clog2(LEN + 1);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load)
      cnt_q <= W'(LEN);
    else if (cnt_q != '0)
      cnt_q <= cnt_q - ONE;
  end

  assign busy = (cnt_q != '0);

  // R7: an open window shrinks by exactly one per edge unless reloaded
  p_countdown_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && !load) |=> (cnt_q == $past(cnt_q) - ONE));

  // R7: a load always opens a full window
  p_load_full_r7: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == W'(LEN)));

endmodule

// File: rtl/cke_edge_classifier.sv
module cke_edge_classifier
  import cke_tracker_pkg::*;
(
  input  pstate_e st,
  input  logic    prev_hi,
  input  logic    cur_hi,
  input  cmd_e    cmd,
  input  logic    bank_active,
  output pstate_e nxt,
  output logic    enter,
  output logic    leave,
  output logic    sref_leave,
  output logic    bad
);
  always_comb begin
    nxt        = st;
    enter      = 1'b0;
    leave      = 1'b0;
    sref_leave = 1'b0;
    bad        = 1'b0;
    if (st != PS_NORM) begin
      if (prev_hi && cur_hi) begin
        nxt = st;
      end else if (prev_hi && !cur_hi) begin
        nxt        = PS_NORM;
        leave      = 1'b1;
        sref_leave = (st == PS_SREF);
        bad        = !is_quiet(cmd);
      end else begin
        bad = 1'b1;
      end
    end else begin
      if (!prev_hi && !cur_hi) begin
        nxt = PS_NORM;
      end else if (!prev_hi && cur_hi) begin
        if (is_quiet(cmd)) begin
          nxt   = bank_active ? PS_APD : PS_PPD;
          enter = 1'b1;
        end else if (cmd == C_REF && !bank_active) begin
          nxt   = PS_SREF;
          enter = 1'b1;
        end else begin
          bad = 1'b1;
        end
      end else begin
        bad = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cke_power_tracker.sv
module cke_power_tracker
  import cke_tracker_pkg::*;
#(
  parameter int XS_CYC  = 8,
  parameter int DLL_CYC = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cke_n,
  input  logic [2:0] cmd,
  input  logic       bank_active,
  input  logic       dll_off,
  output logic [1:0] pstate_o,
  output logic       enter_o,
  output logic       exit_o,
  output logic       err_o,
  output logic       xs_viol_o,
  output logic       dll_viol_o
);
  pstate_e st_q, st_nxt;
  logic    prev_q;
  cmd_e    cmd_e_w;
  logic    ev_enter, ev_leave, ev_sref_leave, ev_bad;
  logic    xs_busy, dll_busy;
  logic    in_norm_ll;

  assign cmd_e_w = cmd_e'(cmd);

  cke_edge_classifier u_cls (
    .st          (st_q),
    .prev_hi     (prev_q),
    .cur_hi      (cke_n),
    .cmd         (cmd_e_w),
    .bank_active (bank_active),
    .nxt         (st_nxt),
    .enter       (ev_enter),
    .leave       (ev_leave),
    .sref_leave  (ev_sref_leave),
    .bad         (ev_bad)
  );

  cke_hold_timer #(.LEN(XS_CYC)) u_xs_win (
    .clk  (clk),
    .rst  (rst),
    .load (ev_sref_leave),
    .busy (xs_busy)
  );

  cke_hold_timer #(.LEN(DLL_CYC)) u_dll_win (
    .clk  (clk),
    .rst  (rst),
    .load (ev_sref_leave && dll_off),
    .busy (dll_busy)
  );

  assign in_norm_ll = (st_q == PS_NORM) && !prev_q && !cke_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= PS_NORM;
      prev_q     <= 1'b0;
      enter_o    <= 1'b0;
      exit_o     <= 1'b0;
      err_o      <= 1'b0;
      xs_viol_o  <= 1'b0;
      dll_viol_o <= 1'b0;
    end else begin
      st_q       <= st_nxt;
      prev_q     <= cke_n;
      enter_o    <= ev_enter;
      exit_o     <= ev_leave;
      err_o      <= ev_bad;
      xs_viol_o  <= (st_q == PS_NORM) && xs_busy && !is_quiet(cmd_e_w);
      dll_viol_o <= in_norm_ll && dll_busy && (cmd_e_w == C_READ);
    end
  end

  assign pstate_o = st_q;

  // R2: a held-high enable keeps any low-power state
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (st_q != PS_NORM && prev_q && cke_n) |=> (st_q == $past(st_q) && !err_o));

  // R3: an exit pulse means the state returned to normal from a low-power one
  p_exit_state_r3: assert property (@(posedge clk) disable iff (rst)
    exit_o |-> (pstate_o == 2'd0 && $past(pstate_o) != 2'd0));

  // R4: an entry pulse always lands in a low-power state
  p_enter_state_r4: assert property (@(posedge clk) disable iff (rst)
    enter_o |-> (pstate_o != 2'd0 && $past(pstate_o) == 2'd0));

  // R8: a DLL violation only reports from normal operation
  p_dll_norm_r8: assert property (@(posedge clk) disable iff (rst)
    dll_viol_o |-> ($past(st_q) == PS_NORM && $past(dll_busy)));

  // R7: a window violation needs an open window on the reporting edge
  p_xs_open_r7: assert property (@(posedge clk) disable iff (rst)
    xs_viol_o |-> $past(xs_busy));

  // R9: an illegal combination never moves the state, except on an exit edge
  p_err_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (ev_bad && !ev_leave) |=> $stable(st_q));

endmodule

// File: tb/tb_cke_power_tracker.sv
`timescale 1ns/1ps
module tb_cke_power_tracker;
  localparam int XS  = 4;
  localparam int DLL = 6;
  localparam int DESEL = 0, NOP = 1, ACT = 2, RD = 3, WR = 4, PRE = 5, REF = 6, MRS = 7;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cke_n = 1'b0;
  logic [2:0] cmd = 3'd1;
  logic       bank_active = 1'b0;
  logic       dll_off = 1'b0;
  logic [1:0] pstate_o;
  logic       enter_o, exit_o, err_o, xs_viol_o, dll_viol_o;

  int checks = 0;
  int errors = 0;

  int m_st = 0, m_prev = 0, m_xs = 0, m_dll = 0;

  always #4 clk = ~clk;

  cke_power_tracker #(.XS_CYC(XS), .DLL_CYC(DLL)) dut (
    .clk(clk), .rst(rst), .cke_n(cke_n), .cmd(cmd),
    .bank_active(bank_active), .dll_off(dll_off),
    .pstate_o(pstate_o), .enter_o(enter_o), .exit_o(exit_o),
    .err_o(err_o), .xs_viol_o(xs_viol_o), .dll_viol_o(dll_viol_o)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input string tag, input int ck, input int c, input int ba, input int doff);
    int e_st, e_en, e_ex, e_er, e_xv, e_dv, quiet;
    cke_n = ck[0]; cmd = c[2:0]; bank_active = ba[0]; dll_off = doff[0];
    quiet = (c == DESEL || c == NOP);
    e_st = m_st; e_en = 0; e_ex = 0; e_er = 0;
    e_xv = (m_st == 0 && m_xs > 0 && !quiet);
    e_dv = (m_st == 0 && m_prev == 0 && ck == 0 && m_dll > 0 && c == RD);
    if (m_xs > 0) m_xs--;
    if (m_dll > 0) m_dll--;
    if (m_st != 0) begin
      if (m_prev == 1 && ck == 1) e_st = m_st;
      else if (m_prev == 1 && ck == 0) begin
        e_st = 0; e_ex = 1; e_er = !quiet;
        if (m_st == 3) begin
          m_xs = XS;
          if (doff) m_dll = DLL;
        end
      end else e_er = 1;
    end else begin
      if (m_prev == 0 && ck == 0) e_st = 0;
      else if (m_prev == 0 && ck == 1) begin
        if (quiet) begin e_st = ba ? 2 : 1; e_en = 1; end
        else if (c == REF && ba == 0) begin e_st = 3; e_en = 1; end
        else e_er = 1;
      end else e_er = 1;
    end
    m_st = e_st; m_prev = ck;
    @(posedge clk);
    @(negedge clk);
    check(tag, "pstate", int'(pstate_o), e_st);
    check(tag, "enter", int'(enter_o), e_en);
    check(tag, "exit", int'(exit_o), e_ex);
    check(tag, "err", int'(err_o), e_er);
    check(tag, "xs_viol", int'(xs_viol_o), e_xv);
    check(tag, "dll_viol", int'(dll_viol_o), e_dv);
  endtask

  initial begin : watchdog
    #(8ns * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cke_n = 1'b1;
    @(negedge clk);
    // R1: reset state, outputs low, previous level low
    check("R1", "pstate", int'(pstate_o), 0);
    check("R1", "flags", int'({enter_o, exit_o, err_o, xs_viol_o, dll_viol_o}), 0);
    rst = 1'b0;
    cke_n = 1'b0;
    // R6 and R10: steady normal operation with several commands
    step("R6", 0, NOP, 0, 0);
    step("R6", 0, ACT, 1, 0);
    step("R6", 0, RD, 1, 0);
    step("R6", 0, MRS, 0, 0);
    // R4: precharge power-down, R2 hold, R3 clean exit
    step("R4", 1, NOP, 0, 0);
    step("R2", 1, ACT, 0, 0);
    step("R2", 1, WR, 1, 0);
    step("R3", 0, NOP, 0, 0);
    step("R6", 0, DESEL, 1, 0);
    // R4: active power-down, R3 exit with a bad command
    step("R4", 1, DESEL, 1, 0);
    step("R2", 1, REF, 1, 0);
    step("R3", 0, ACT, 1, 0);
    step("R6", 0, NOP, 0, 0);
    // R5: self refresh entry, hold, exit with DLL off
    step("R5", 1, REF, 0, 0);
    step("R2", 1, MRS, 0, 0);
    step("R2", 1, PRE, 0, 0);
    step("R2", 1, NOP, 0, 0);
    step("R3", 0, NOP, 0, 1);
    // R7 / R8: window and DLL lock interval
    step("R7", 0, ACT, 0, 0);
    step("R7", 0, NOP, 0, 0);
    step("R8", 0, RD, 1, 0);
    step("R7", 0, NOP, 1, 0);
    step("R7", 0, ACT, 1, 0);
    step("R8", 0, RD, 1, 0);
    step("R8", 0, RD, 1, 0);
    step("R8", 0, WR, 1, 0);
    // R5: refresh with an active bank is illegal
    step("R5", 1, REF, 1, 0);
    step("R9", 0, NOP, 1, 0);
    step("R6", 0, NOP, 0, 0);
    // R9: other illegal combinations
    step("R9", 1, ACT, 0, 0);
    step("R9", 1, NOP, 0, 0);
    step("R9", 0, NOP, 0, 0);
    step("R6", 0, NOP, 0, 0);
    // R8: self refresh exit with DLL on gives no DLL violation
    step("R5", 1, REF, 0, 0);
    step("R3", 0, DESEL, 0, 0);
    step("R8", 0, RD, 0, 0);
    step("R7", 0, WR, 0, 0);
    step("R7", 0, NOP, 0, 0);
    step("R7", 0, NOP, 0, 0);
    step("R7", 0, PRE, 0, 0);
    // R4: entry from inside an exit window is legal
    step("R5", 1, REF, 0, 0);
    step("R3", 0, NOP, 0, 1);
    step("R4", 1, NOP, 0, 0);
    step("R3", 0, NOP, 0, 0);
    step("R8", 0, RD, 0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule